// File: doc/BRIEF.md
# Floppy Controller Host Front End: Phase Sequencer

This block is the register face of a floppy disk controller as seen by the host processor. A two-bit address selects one of four byte-wide locations: a drive/motor output latch, the main status byte (on read) or the rate-select control (on write), the command/result data port, and an unused slot. The block tracks the idle, command, execution and result phases of each controller command and builds the main status byte from these phases. It counts incoming command bytes against the length of the opcode and streams each accepted byte to the execution side. It answers unknown opcodes itself and carries out the software reset requested through the rate-select location.

The mechanics of seek, read and write are not part of this block. An execution engine picks up `exec_start` and the streamed command bytes. It writes its result bytes into a small buffer through a write port and reports completion with `exec_done` and a result count. The host then drains those bytes through the data port. The non-DMA flag, set by the timing-setup command, is kept through every status clear and through software reset. The four per-drive seek flags are kept through the phase changes of a command.

Top module: `fdc_phase_seq`

## Requirements
- R1: After the synchronous reset, the status byte reads 0x80, `irq` is 0 and `non_dma` is 0.
- R2: The status byte is laid out as {request, direction, non_dma, busy, seek_active[3:0]}, with bit 7 the request flag and direction 1 meaning controller-to-host. Address 1 returns it, and a status read changes no state.
- R3: A data write (address 2) in idle clears the phase flags, keeps the seek-active bits and the non-DMA bit, and sets request and busy (for example 0xB2 with non_dma and drive 1 active). Opcodes with more than one byte then wait for the rest.
- R4: Command lengths: 0x03 timing-setup is 3 bytes; 0x04 drive-status is 2; 0x07 recalibrate is 2; 0x08 interrupt-status is 1; 0x0F seek is 3; (op & 0x1F)==0x06 read is 9; (op & 0x3F)==0x05 write is 9; (op & 0xBF)==0x0A read-ID is 2. `exec_start` pulses only with the final byte, and during execution the status shows busy without request.
- R5: `exec_done` with a nonzero count enters the result phase. The status shows request, direction and busy, the result index restarts at 0, and `irq` rises. A count of zero returns to idle.
- R6: Each data read in the result phase returns the next buffered result byte, starting at slot 0, and drops `irq`. After the last byte, the status reads request only (plus non_dma and seek bits).
- R7: A data read in idle returns result slot 0 and clears request, direction and busy. A following command byte is still accepted.
- R8: An opcode outside R4 gives no `exec_start` and enters the result phase at once with a single result byte 0x80 (invalid command; bits 7:6 of that byte are the termination code: 00 normal, 01 abnormal, 10 invalid, 11 polling failure).
- R9: Timing-setup byte 1 loads `step_rate` (bits 7:4) and `head_unload` (bits 3:0). Byte 2 loads `head_load` (bits 7:1) and `non_dma` (bit 0).
- R10: A write to address 1 always loads `data_rate` from bits 1:0. With bit 7 set, it also clears every status bit except non_dma, raises `reset_pending`, and makes data writes ignored until the reset ends.
- R11: `RESET_CYCLES` cycles after a software reset begins, `reset_pending` falls, `irq` rises and the status shows request.
- R12: A data write while direction is 1 is ignored (the pending result byte is unchanged) and `wr_err` pulses for one cycle.
- R13: Address 0 is a read/write latch whose value appears on `dor_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 2 | 0 output latch, 1 status/rate select, 2 data port |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| irq | output | 1 | Interrupt request |
| wr_err | output | 1 | Pulse: data write refused (wrong direction) |
| cmd_vld | output | 1 | Pulse: command byte accepted |
| cmd_idx | output | 4 | Position of accepted byte in the command |
| cmd_dat | output | 8 | Accepted command byte |
| exec_start | output | 1 | Pulse: command complete, execution begins |
| exec_opcode | output | 8 | First byte of the current command |
| exec_done | input | 1 | Execution finished |
| exec_res_cnt | input | $clog2(RES_DEPTH+1) | Number of result bytes |
| res_wr_en | input | 1 | Result buffer write enable |
| res_wr_idx | input | $clog2(RES_DEPTH) | Result buffer write slot |
| res_wr_data | input | 8 | Result buffer write data |
| drv_seek_set | input | 4 | Set per-drive seek-active flags |
| drv_seek_clr | input | 4 | Clear per-drive seek-active flags |
| dor_out | output | 8 | Output latch contents |
| data_rate | output | 2 | Selected data rate |
| step_rate | output | 4 | Stored step-rate time |
| head_unload | output | 4 | Stored head-unload time |
| head_load | output | 7 | Stored head-load time |
| non_dma | output | 1 | Non-DMA mode flag |
| reset_pending | output | 1 | Software reset in progress |

## Verification
The assertions assume that the host never raises read and write together and that there is at least one idle cycle between successive host strobes, so that the synchronous result buffer can follow the index update. They also assume that `exec_done` arrives only while the block is executing. The bench drives each host access as a one-cycle strobe from a task that begins on a falling edge and releases on the next one. It pulses `exec_done` only after `exec_start` has been seen and after the result bytes are loaded, and in this way stays inside those assumptions.

// File: rtl/fdc_phase_pkg.sv
package fdc_phase_pkg;

  localparam int CMD_IDX_W = 4;

  localparam logic [1:0] ADR_OUTLATCH = 2'd0;
  localparam logic [1:0] ADR_STATUS   = 2'd1;
  localparam logic [1:0] ADR_DATA     = 2'd2;

  localparam logic [7:0] OP_TIMING    = 8'h03;
  localparam logic [7:0] OP_DRV_STAT  = 8'h04;
  localparam logic [7:0] OP_RECAL     = 8'h07;
  localparam logic [7:0] OP_INT_STAT  = 8'h08;
  localparam logic [7:0] OP_SEEK      = 8'h0F;

  // termination code in bits 7:6 of the first result byte
  localparam logic [1:0] TERM_NORMAL   = 2'b00;
  localparam logic [1:0] TERM_ABNORMAL = 2'b01;
  localparam logic [1:0] TERM_INVALID  = 2'b10;
  localparam logic [1:0] TERM_NOTREADY = 2'b11;
  localparam logic [7:0] RES_BAD_OPCODE = {TERM_INVALID, 6'b0};

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_EXEC,
    PH_RES,
    PH_RST
  } phase_e;

endpackage

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
  import fdc_phase_pkg::*;
(
  input  logic [7:0]           opcode,
  output logic                 known,
  output logic                 needs_exec,
  output logic [CMD_IDX_W-1:0] length
);

  always_comb begin
    known      = 1'b1;
    needs_exec = 1'b1;
    length     = CMD_IDX_W'(1);
    if (opcode == OP_TIMING) begin
      length     = CMD_IDX_W'(3);
      needs_exec = 1'b0;
    end else if (opcode == OP_DRV_STAT) begin
      length = CMD_IDX_W'(2);
    end else if (opcode == OP_RECAL) begin
      length = CMD_IDX_W'(2);
    end else if (opcode == OP_INT_STAT) begin
      length = CMD_IDX_W'(1);
    end else if (opcode == OP_SEEK) begin
      length = CMD_IDX_W'(3);
    end else if ((opcode & 8'h1F) == 8'h06) begin
      length = CMD_IDX_W'(9);
    end else if ((opcode & 8'h3F) == 8'h05) begin
      length = CMD_IDX_W'(9);
    end else if ((opcode & 8'hBF) == 8'h0A) begin
      length = CMD_IDX_W'(2);
    end else begin
      known      = 1'b0;
      needs_exec = 1'b0;
    end
  end

endmodule

// File: rtl/fdc_result_buf.sv
module fdc_result_buf #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/fdc_reset_timer.sv
module fdc_reset_timer #(
  parameter int CYCLES = 50000,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expire
);

  logic [CW-1:0] cnt_q;

  assign expire = (cnt_q == CW'(1)) && !load;

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (load)            cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

endmodule

// File: rtl/fdc_phase_seq.sv
module fdc_phase_seq
  import fdc_phase_pkg::*;
#(
  parameter int RES_DEPTH    = 16,
  parameter int RESET_CYCLES = 50000,
  localparam int RIDX_W = $clog2(RES_DEPTH),
  localparam int CNT_W  = $clog2(RES_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           host_addr,
  input  logic                 host_rd,
  input  logic                 host_wr,
  input  logic [7:0]           host_wdata,
  output logic [7:0]           host_rdata,
  output logic                 irq,
  output logic                 wr_err,
  output logic                 cmd_vld,
  output logic [CMD_IDX_W-1:0] cmd_idx,
  output logic [7:0]           cmd_dat,
  output logic                 exec_start,
  output logic [7:0]           exec_opcode,
  input  logic                 exec_done,
  input  logic [CNT_W-1:0]     exec_res_cnt,
  input  logic                 res_wr_en,
  input  logic [RIDX_W-1:0]    res_wr_idx,
  input  logic [7:0]           res_wr_data,
  input  logic [3:0]           drv_seek_set,
  input  logic [3:0]           drv_seek_clr,
  output logic [7:0]           dor_out,
  output logic [1:0]           data_rate,
  output logic [3:0]           step_rate,
  output logic [3:0]           head_unload,
  output logic [6:0]           head_load,
  output logic                 non_dma,
  output logic                 reset_pending
);

  phase_e               phase_q;
  logic                 rqm_q, dio_q, busy_q, ndma_q, bad_op_q;
  logic [3:0]           seek_q;
  logic [CMD_IDX_W-1:0] byte_cnt_q;
  logic [RIDX_W-1:0]    res_idx_q;
  logic [CNT_W-1:0]     res_cnt_q;
  logic [7:0]           buf_q;
  logic [7:0]           status_byte;

  logic                 dec_known, dec_exec;
  logic [CMD_IDX_W-1:0] dec_len;
  logic [7:0]           dec_op;
  logic                 rst_expire;

  logic data_wr, data_rd, rate_wr, soft_rst, latch_wr;

  assign data_wr  = host_wr && (host_addr == ADR_DATA);
  assign data_rd  = host_rd && (host_addr == ADR_DATA);
  assign rate_wr  = host_wr && (host_addr == ADR_STATUS);
  assign latch_wr = host_wr && (host_addr == ADR_OUTLATCH);
  assign soft_rst = rate_wr && host_wdata[7];

  assign status_byte   = {rqm_q, dio_q, ndma_q, busy_q, seek_q};
  assign non_dma       = ndma_q;
  assign reset_pending = (phase_q == PH_RST);
  assign dec_op        = (phase_q == PH_IDLE) ? host_wdata : exec_opcode;

  fdc_cmd_decode u_dec (
    .opcode     (dec_op),
    .known      (dec_known),
    .needs_exec (dec_exec),
    .length     (dec_len)
  );

  fdc_result_buf #(.DEPTH(RES_DEPTH)) u_buf (
    .clk   (clk),
    .we    (res_wr_en),
    .waddr (res_wr_idx),
    .wdata (res_wr_data),
    .raddr (res_idx_q),
    .rdata (buf_q)
  );

  fdc_reset_timer #(.CYCLES(RESET_CYCLES)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .load   (soft_rst),
    .expire (rst_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= PH_IDLE;
      rqm_q       <= 1'b1;
      dio_q       <= 1'b0;
      busy_q      <= 1'b0;
      ndma_q      <= 1'b0;
      bad_op_q    <= 1'b0;
      seek_q      <= '0;
      byte_cnt_q  <= '0;
      res_idx_q   <= '0;
      res_cnt_q   <= '0;
      host_rdata  <= '0;
      irq         <= 1'b0;
      wr_err      <= 1'b0;
      cmd_vld     <= 1'b0;
      cmd_idx     <= '0;
      cmd_dat     <= '0;
      exec_start  <= 1'b0;
      exec_opcode <= '0;
      dor_out     <= '0;
      data_rate   <= '0;
      step_rate   <= '0;
      head_unload <= '0;
      head_load   <= '0;
    end else begin
      wr_err     <= 1'b0;
      cmd_vld    <= 1'b0;
      exec_start <= 1'b0;
      seek_q     <= (seek_q | drv_seek_set) & ~drv_seek_clr;

      if (latch_wr) dor_out <= host_wdata;
      if (rate_wr)  data_rate <= host_wdata[1:0];
      if (data_rd)  irq <= 1'b0;

      if (host_rd) begin
        case (host_addr)
          ADR_OUTLATCH: host_rdata <= dor_out;
          ADR_STATUS:   host_rdata <= status_byte;
          ADR_DATA:     host_rdata <= (phase_q == PH_RES && bad_op_q) ? RES_BAD_OPCODE : buf_q;
          default:      host_rdata <= '0;
        endcase
      end

      if (soft_rst) begin
        phase_q    <= PH_RST;
        rqm_q      <= 1'b0;
        dio_q      <= 1'b0;
        busy_q     <= 1'b0;
        seek_q     <= '0;
        bad_op_q   <= 1'b0;
        res_idx_q  <= '0;
        byte_cnt_q <= '0;
      end else begin
        case (phase_q)
          PH_IDLE: begin
            if (data_wr) begin
              cmd_vld     <= 1'b1;
              cmd_idx     <= '0;
              cmd_dat     <= host_wdata;
              exec_opcode <= host_wdata;
              rqm_q       <= 1'b1;
              busy_q      <= 1'b1;
              dio_q       <= 1'b0;
              if (!dec_known) begin
                phase_q   <= PH_RES;
                dio_q     <= 1'b1;
                bad_op_q  <= 1'b1;
                res_cnt_q <= CNT_W'(1);
                res_idx_q <= '0;
              end else if (dec_len == CMD_IDX_W'(1)) begin
                phase_q    <= PH_EXEC;
                rqm_q      <= 1'b0;
                exec_start <= 1'b1;
              end else begin
                phase_q    <= PH_CMD;
                byte_cnt_q <= CMD_IDX_W'(1);
              end
            end else if (data_rd) begin
              rqm_q  <= 1'b0;
              dio_q  <= 1'b0;
              busy_q <= 1'b0;
            end
          end

          PH_CMD: begin
            if (data_wr) begin
              cmd_vld <= 1'b1;
              cmd_idx <= byte_cnt_q;
              cmd_dat <= host_wdata;
              if (exec_opcode == OP_TIMING) begin
                if (byte_cnt_q == CMD_IDX_W'(1)) begin
                  step_rate   <= host_wdata[7:4];
                  head_unload <= host_wdata[3:0];
                end else begin
                  head_load <= host_wdata[7:1];
                  ndma_q    <= host_wdata[0];
                end
              end
              if (byte_cnt_q == dec_len - CMD_IDX_W'(1)) begin
                byte_cnt_q <= '0;
                if (dec_exec) begin
                  phase_q    <= PH_EXEC;
                  rqm_q      <= 1'b0;
                  exec_start <= 1'b1;
                end else begin
                  phase_q <= PH_IDLE;
                  busy_q  <= 1'b0;
                end
              end else begin
                byte_cnt_q <= byte_cnt_q + CMD_IDX_W'(1);
              end
            end
          end

          PH_EXEC: begin
            if (exec_done) begin
              res_idx_q <= '0;
              if (exec_res_cnt == '0) begin
                phase_q <= PH_IDLE;
                rqm_q   <= 1'b1;
                busy_q  <= 1'b0;
              end else begin
                phase_q   <= PH_RES;
                rqm_q     <= 1'b1;
                dio_q     <= 1'b1;
                busy_q    <= 1'b1;
                res_cnt_q <= exec_res_cnt;
                irq       <= 1'b1;
              end
            end
          end

          PH_RES: begin
            if (data_wr) begin
              wr_err <= 1'b1;
            end else if (data_rd) begin
              if (CNT_W'(res_idx_q) + CNT_W'(1) >= res_cnt_q) begin
                phase_q   <= PH_IDLE;
                rqm_q     <= 1'b1;
                dio_q     <= 1'b0;
                busy_q    <= 1'b0;
                bad_op_q  <= 1'b0;
                res_idx_q <= '0;
              end else begin
                res_idx_q <= res_idx_q + RIDX_W'(1);
              end
            end
          end

          PH_RST: begin
            if (rst_expire) begin
              phase_q <= PH_IDLE;
              rqm_q   <= 1'b1;
              irq     <= 1'b1;
            end
          end

          default: phase_q <= PH_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/fdc_phase_seq_chk.sv
module fdc_phase_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] host_addr,
  input logic       host_rd,
  input logic       host_wr,
  input logic [7:0] host_wdata,
  input logic       rqm,
  input logic       dio,
  input logic       busy,
  input logic       ndma,
  input logic       pend,
  input logic       irq,
  input logic       wr_err,
  input logic       exec_start
);

  // R2
  idle_no_direction_chk: assert property (@(posedge clk) disable iff (rst)
    (rqm && !busy) |-> !dio);

  // R5
  result_flags_chk: assert property (@(posedge clk) disable iff (rst)
    dio |-> (rqm && busy));

  // R4
  exec_busy_chk: assert property (@(posedge clk) disable iff (rst)
    exec_start |-> (busy && !rqm && !dio));

  // R6
  read_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == 2'd2 && dio) |=> !irq);

  // R10
  ndma_survives_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 2'd1 && host_wdata[7]) |=> (ndma == $past(ndma)));

  // R10
  pending_flags_clear_chk: assert property (@(posedge clk) disable iff (rst)
    pend |-> (!rqm && !dio && !busy));

  // R12
  wrong_dir_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 2'd2 && dio && !pend) |=> wr_err);

endmodule

bind fdc_phase_seq fdc_phase_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_addr  (host_addr),
  .host_rd    (host_rd),
  .host_wr    (host_wr),
  .host_wdata (host_wdata),
  .rqm        (rqm_q),
  .dio        (dio_q),
  .busy       (busy_q),
  .ndma       (ndma_q),
  .pend       (reset_pending),
  .irq        (irq),
  .wr_err     (wr_err),
  .exec_start (exec_start)
);

// File: tb/tb_fdc_phase_seq.sv
module tb_fdc_phase_seq;

  localparam int RES_DEPTH = 16;
  localparam int RST_CYC   = 32;
  localparam int RIDX_W    = $clog2(RES_DEPTH);
  localparam int CNT_W     = $clog2(RES_DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [1:0]        host_addr = '0;
  logic              host_rd = 0, host_wr = 0;
  logic [7:0]        host_wdata = '0;
  logic [7:0]        host_rdata;
  logic              irq, wr_err, cmd_vld, exec_start, non_dma, reset_pending;
  logic [3:0]        cmd_idx, step_rate, head_unload;
  logic [7:0]        cmd_dat, exec_opcode, dor_out;
  logic              exec_done = 0;
  logic [CNT_W-1:0]  exec_res_cnt = '0;
  logic              res_wr_en = 0;
  logic [RIDX_W-1:0] res_wr_idx = '0;
  logic [7:0]        res_wr_data = '0;
  logic [3:0]        drv_seek_set = '0, drv_seek_clr = '0;
  logic [1:0]        data_rate;
  logic [6:0]        head_load;

  fdc_phase_seq #(.RES_DEPTH(RES_DEPTH), .RESET_CYCLES(RST_CYC)) dut (
    .clk, .rst, .host_addr, .host_rd, .host_wr, .host_wdata, .host_rdata,
    .irq, .wr_err, .cmd_vld, .cmd_idx, .cmd_dat, .exec_start, .exec_opcode,
    .exec_done, .exec_res_cnt, .res_wr_en, .res_wr_idx, .res_wr_data,
    .drv_seek_set, .drv_seek_clr, .dor_out, .data_rate, .step_rate,
    .head_unload, .head_load, .non_dma, .reset_pending
  );

  int tests = 0, fails = 0;
  bit finished = 0;
  logic seen_err, seen_exec, seen_vld;
  logic [3:0] seen_idx;
  logic [7:0] seen_dat, rd_val;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
    seen_err = wr_err; seen_exec = exec_start; seen_vld = cmd_vld;
    seen_idx = cmd_idx; seen_dat = cmd_dat;
  endtask

  task automatic hread(input logic [1:0] a);
    @(negedge clk);
    host_addr = a; host_rd = 1;
    @(negedge clk);
    host_rd = 0;
    rd_val = host_rdata;
  endtask

  task automatic chk_status(input string req, input logic [7:0] exp);
    hread(2'd1);
    chk(req, rd_val, exp);
  endtask

  task automatic load_result(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      res_wr_en = 1; res_wr_idx = RIDX_W'(i); res_wr_data = base + 8'(i);
    end
    @(negedge clk);
    res_wr_en = 0;
  endtask

  task automatic finish_exec(input int n);
    @(negedge clk);
    exec_done = 1; exec_res_cnt = CNT_W'(n);
    @(negedge clk);
    exec_done = 0;
  endtask

  task automatic t_reset;
    chk_status("R1 status", 8'h80);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 non_dma", {7'b0, non_dma}, 8'h00);
  endtask

  task automatic t_latch;
    hwrite(2'd0, 8'h1C);
    chk("R13 dor_out", dor_out, 8'h1C);
    hread(2'd0);
    chk("R13 readback", rd_val, 8'h1C);
  endtask

  task automatic t_timing_setup;
    hwrite(2'd2, 8'h03);
    chk_status("R3 first byte", 8'h90);
    hwrite(2'd2, 8'hAF);
    hwrite(2'd2, 8'h1B);
    chk("R9 step", {4'b0, step_rate}, 8'h0A);
    chk("R9 unload", {4'b0, head_unload}, 8'h0F);
    chk("R9 load", {1'b0, head_load}, 8'h0D);
    chk("R9 ndma", {7'b0, non_dma}, 8'h01);
    chk_status("R9 idle after setup", 8'hA0);
  endtask

  task automatic t_seek;
    @(negedge clk); drv_seek_set = 4'b0010;
    @(negedge clk); drv_seek_set = 4'b0000;
    chk_status("R2 drive bit", 8'hA2);
    hwrite(2'd2, 8'h0F);
    chk_status("R3 keeps drive and ndma", 8'hB2);
    hwrite(2'd2, 8'h01);
    chk("R4 no early start", {7'b0, seen_exec}, 8'h00);
    hwrite(2'd2, 8'h28);
    chk("R4 start on last", {7'b0, seen_exec}, 8'h01);
    chk("R4 stream idx", {4'b0, seen_idx}, 8'h02);
    chk("R4 stream dat", seen_dat, 8'h28);
    chk("R4 opcode", exec_opcode, 8'h0F);
    chk_status("R4 exec status", 8'h32);
    load_result(2, 8'h20);
    finish_exec(2);
    chk("R5 irq", {7'b0, irq}, 8'h01);
    chk_status("R5 result status", 8'hF2);
    hread(2'd2);
    chk("R6 byte0", rd_val, 8'h20);
    chk("R6 irq drop", {7'b0, irq}, 8'h00);
    hread(2'd2);
    chk("R6 byte1", rd_val, 8'h21);
    chk_status("R6 back to idle", 8'hA2);
  endtask

  task automatic t_invalid;
    hwrite(2'd2, 8'h1F);
    chk("R8 no start", {7'b0, seen_exec}, 8'h00);
    chk_status("R8 result status", 8'hF2);
    hread(2'd2);
    chk("R8 code", rd_val, 8'h80);
    chk_status("R8 idle", 8'hA2);
  endtask

  task automatic t_dir_error;
    hwrite(2'd2, 8'h00);
    hwrite(2'd2, 8'h55);
    chk("R12 wr_err", {7'b0, seen_err}, 8'h01);
    chk("R12 not accepted", {7'b0, seen_vld}, 8'h00);
    hread(2'd2);
    chk("R12 result intact", rd_val, 8'h80);
    chk_status("R12 idle", 8'hA2);
  endtask

  task automatic t_idle_read;
    hread(2'd2);
    chk("R7 slot0", rd_val, 8'h20);
    chk_status("R7 flags cleared", 8'h22);
    hwrite(2'd2, 8'h08);
    chk("R7 cmd accepted", {7'b0, seen_exec}, 8'h01);
    chk_status("R4 single-byte exec", 8'h32);
    finish_exec(0);
    chk("R5 zero count no irq", {7'b0, irq}, 8'h00);
    chk_status("R5 zero count idle", 8'hA2);
  endtask

  task automatic t_long_read;
    hwrite(2'd2, 8'h46);
    for (int i = 1; i < 8; i++) hwrite(2'd2, 8'(i));
    chk("R4 read not yet", {7'b0, seen_exec}, 8'h00);
    hwrite(2'd2, 8'hFF);
    chk("R4 read start", {7'b0, seen_exec}, 8'h01);
    chk("R4 read idx", {4'b0, seen_idx}, 8'h08);
    load_result(7, 8'h40);
    finish_exec(7);
    for (int i = 0; i < 7; i++) begin
      hread(2'd2);
      chk("R6 read results", rd_val, 8'h40 + 8'(i));
    end
    chk_status("R6 idle after seven", 8'hA2);
  endtask

  task automatic t_soft_reset;
    hwrite(2'd1, 8'h82);
    chk("R10 rate", {6'b0, data_rate}, 8'h02);
    chk("R10 pending", {7'b0, reset_pending}, 8'h01);
    chk_status("R10 only ndma kept", 8'h20);
    hwrite(2'd2, 8'h03);
    chk("R10 data write ignored", {7'b0, seen_vld}, 8'h00);
    chk("R11 no early irq", {7'b0, irq}, 8'h00);
    repeat (RST_CYC + 4) @(negedge clk);
    chk("R11 irq", {7'b0, irq}, 8'h01);
    chk("R11 pending done", {7'b0, reset_pending}, 8'h00);
    chk_status("R11 idle", 8'hA0);
    hwrite(2'd1, 8'h01);
    chk("R10 rate no reset", {6'b0, data_rate}, 8'h01);
    chk("R10 no reset without bit7", {7'b0, reset_pending}, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_latch();
    t_timing_setup();
    t_seek();
    t_invalid();
    t_dir_error();
    t_idle_read();
    t_long_read();
    t_soft_reset();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule